// File: doc/BRIEF.md
# Luma DC Inverse Hadamard Dequantizer

This block reconstructs the sixteen DC terms of an intra 16x16 luma macroblock. It receives the decoded DC levels as a dense 4x4 array of signed 16-bit values in row order, together with a dequantization scale. It runs a two-pass butterfly inverse Walsh-Hadamard transform, multiplies each result by the scale, and applies rounding and an arithmetic right shift. Each result is then saturated to 16 bits.

The results are not returned in raster order. Each one lands in the output lane numbered by the 4x4 sub-block whose DC slot it feeds, so the residual stage can pick its DC directly. A scale too large for the 16-bit multiplier path is reduced before use, and the final shift shrinks to make up for it. A bypass mode skips both the transform and the scaling. In that mode it only moves the inputs into the same sub-block slots.

A transfer starts with a one-cycle `start_i` pulse that carries all 16 coefficients, the scale and the bypass flag. The result vector is valid in the cycle where `done_o` is high.

Top module: `dc_hadamard_dequant`

## Requirements
- R1: Horizontal pass. For each input row r holding a0..a3 (input element r*4+c sits at `coef_i[(r*4+c)*16 +: 16]`), let p=a0+a1, m=a0-a1, d=a2-a3 and s=a2+a3. Intermediate columns 0..3 of row r are p+s, p-s, m-d and m+d. No intermediate sum overflows.
- R2: Vertical pass. For intermediate column i holding rows t0..t3, let p=t0+t2, m=t0-t2, d=t1-t3 and s=t1+t3. Results k=0..3 of column i are p+s, m+d, m-d and p-s.
- R3: For a scale of 32767 or less, each transformed value v is dequantized as floor((v*scale + 128) / 256), which is an arithmetic right shift by 8.
- R4: Result k of column i goes to output lane L = A[k] + B[i], where A = (0,1,4,5) and B = (0,2,8,10). Lane L is `res_o[L*16 +: 16]`.
- R5: For a scale above 32767, the effective scale is scale>>7 and each value is floor((v*(scale>>7) + 1) / 2).
- R6: A dequantized value above 32767 is output as 32767. A value below -32768 is output as -32768.
- R7: With `bypass_i` high at start, input element r*4+c is copied unchanged to lane A[c] + B[r]. The scale has no effect in this mode.
- R8: A start accepted at clock edge E gives `done_o` high for exactly one cycle, the one after edge E+2. `res_o` changes only as `done_o` rises and holds otherwise.
- R9: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`. A start seen while busy is ignored and changes neither the result nor the number of done pulses.
- R10: During and right after reset, `done_o` and `busy_o` are low and `res_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accepts a transfer when not busy |
| bypass_i | input | 1 | Copy inputs to their sub-block lanes with no transform |
| scale_i | input | SCALE_W (22) | Unsigned dequantization scale |
| coef_i | input | 16*COEF_W (256) | 4x4 DC levels in row order |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle result-valid strobe |
| res_o | output | 16*COEF_W (256) | Results indexed by sub-block |

## Verification
The assertions cover the handshake on every cycle:
- the fixed three-edge latency from accept to done;
- done lasting exactly one cycle;
- busy following an accepted start;
- the block being idle while done is high;
- the result vector holding still outside done.

The arithmetic can only be shown by the bench scenarios, which compare every lane with an independently computed model. These scenarios cover:
- the butterfly orderings and the scattered lane mapping;
- rounding of negative products;
- the reduced-scale path;
- saturation at both ends;
- bypass placement;
- a start that arrives while the block is busy and must be ignored.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int unsigned NUM_COEF = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_COL} dcq_state_e;

  // lane of result k from column i
  function automatic logic [3:0] slot_of(input int k, input int i);
    logic [3:0] kb, ib;
    case (k)
      0: kb = 4'd0;
      1: kb = 4'd1;
      2: kb = 4'd4;
      default: kb = 4'd5;
    endcase
    case (i)
      0: ib = 4'd0;
      1: ib = 4'd2;
      2: ib = 4'd8;
      default: ib = 4'd10;
    endcase
    return kb + ib;
  endfunction
endpackage

// File: rtl/dcq_butterfly.sv
module dcq_butterfly #(
  parameter int W_IN      = 16,
  parameter int W_OUT     = 18,
  parameter bit COL_ORDER = 1'b0
) (
  input  logic [4*W_IN-1:0]  d_i,
  output logic [4*W_OUT-1:0] q_o
);
  logic signed [W_OUT-1:0] a [4];
  logic signed [W_OUT-1:0] y [4];
  logic signed [W_OUT-1:0] z0, z1, z2, z3;

  always_comb begin
    for (int n = 0; n < 4; n++) a[n] = W_OUT'($signed(d_i[n*W_IN +: W_IN]));
  end

  generate
    if (COL_ORDER) begin : g_col
      assign z0 = a[0] + a[2];
      assign z1 = a[0] - a[2];
      assign z2 = a[1] - a[3];
      assign z3 = a[1] + a[3];
      assign y[0] = z0 + z3;
      assign y[1] = z1 + z2;
      assign y[2] = z1 - z2;
      assign y[3] = z0 - z3;
    end else begin : g_row
      assign z0 = a[0] + a[1];
      assign z1 = a[0] - a[1];
      assign z2 = a[2] - a[3];
      assign z3 = a[2] + a[3];
      assign y[0] = z0 + z3;
      assign y[1] = z0 - z3;
      assign y[2] = z1 - z2;
      assign y[3] = z1 + z2;
    end
  endgenerate

  generate
    for (genvar n = 0; n < 4; n++) begin : g_pack
      assign q_o[n*W_OUT +: W_OUT] = y[n];
    end
  endgenerate
endmodule

// File: rtl/dcq_lane.sv
module dcq_lane #(
  parameter int SUM_W   = 20,
  parameter int SCALE_W = 22,
  parameter int OUT_W   = 16
) (
  input  logic [SUM_W-1:0]   v_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               big_i,
  output logic [OUT_W-1:0]   q_o
);
  localparam int PROD_W = SUM_W + SCALE_W + 1;

  logic signed [PROD_W-1:0] vx, sx, prod, rnd;
  logic pos_ovf, neg_ovf;

  assign vx   = PROD_W'($signed(v_i));
  assign sx   = $signed({{(PROD_W-SCALE_W){1'b0}}, scale_i});
  assign prod = vx * sx;
  // reduced scale uses shift 1 with rounding constant 1
  assign rnd  = big_i ? ((prod + PROD_W'(1)) >>> 1) : ((prod + PROD_W'(128)) >>> 8);

  assign pos_ovf = !rnd[PROD_W-1] && (|rnd[PROD_W-2:OUT_W-1]);
  assign neg_ovf = rnd[PROD_W-1] && !(&rnd[PROD_W-2:OUT_W-1]);

  always_comb begin
    if (pos_ovf)      q_o = {1'b0, {(OUT_W-1){1'b1}}};
    else if (neg_ovf) q_o = {1'b1, {(OUT_W-1){1'b0}}};
    else              q_o = rnd[OUT_W-1:0];
  end
endmodule

// File: rtl/dc_hadamard_dequant.sv
module dc_hadamard_dequant
  import dcq_pkg::*;
#(
  parameter int COEF_W  = 16,
  parameter int SCALE_W = 22
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         bypass_i,
  input  logic [SCALE_W-1:0]           scale_i,
  input  logic [NUM_COEF*COEF_W-1:0]   coef_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [NUM_COEF*COEF_W-1:0]   res_o
);
  localparam int ROW_W = COEF_W + 2;
  localparam int SUM_W = COEF_W + 4;
  localparam int BIG_BIT = 15;
  localparam int BIG_SHR = 7;

  dcq_state_e state_q;
  logic [COEF_W-1:0]  coef_q [NUM_COEF];
  logic [ROW_W-1:0]   tmp_q  [NUM_COEF];
  logic [ROW_W-1:0]   row_d  [NUM_COEF];
  logic [COEF_W-1:0]  res_q  [NUM_COEF];
  logic [COEF_W-1:0]  res_d  [NUM_COEF];
  logic [COEF_W-1:0]  deq    [4][4];
  logic [SCALE_W-1:0] scale_q, scale_eff;
  logic               bypass_q, scale_big, done_q, accept;

  assign accept    = start_i && (state_q == ST_IDLE);
  assign scale_big = |scale_q[SCALE_W-1:BIG_BIT];
  assign scale_eff = scale_big ? (scale_q >> BIG_SHR) : scale_q;

  // horizontal pass
  generate
    for (genvar r = 0; r < 4; r++) begin : g_row
      logic [4*ROW_W-1:0] q_pk;
      dcq_butterfly #(.W_IN(COEF_W), .W_OUT(ROW_W), .COL_ORDER(1'b0)) i_bf (
        .d_i({coef_q[r*4+3], coef_q[r*4+2], coef_q[r*4+1], coef_q[r*4]}),
        .q_o(q_pk)
      );
      for (genvar k = 0; k < 4; k++) begin : g_out
        assign row_d[r*4+k] = q_pk[k*ROW_W +: ROW_W];
      end
    end
  endgenerate

  // vertical pass and dequantization
  generate
    for (genvar i = 0; i < 4; i++) begin : g_col
      logic [4*SUM_W-1:0] q_pk;
      dcq_butterfly #(.W_IN(ROW_W), .W_OUT(SUM_W), .COL_ORDER(1'b1)) i_bf (
        .d_i({tmp_q[12+i], tmp_q[8+i], tmp_q[4+i], tmp_q[i]}),
        .q_o(q_pk)
      );
      for (genvar k = 0; k < 4; k++) begin : g_lane
        dcq_lane #(.SUM_W(SUM_W), .SCALE_W(SCALE_W), .OUT_W(COEF_W)) i_lane (
          .v_i    (q_pk[k*SUM_W +: SUM_W]),
          .scale_i(scale_eff),
          .big_i  (scale_big),
          .q_o    (deq[k][i])
        );
      end
    end
  endgenerate

  always_comb begin
    for (int n = 0; n < NUM_COEF; n++) res_d[n] = '0;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 4; i++) begin
        if (bypass_q) res_d[slot_of(k, i)] = coef_q[i*4+k];
        else          res_d[slot_of(k, i)] = deq[k][i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      scale_q  <= '0;
      bypass_q <= 1'b0;
      done_q   <= 1'b0;
      for (int n = 0; n < NUM_COEF; n++) begin
        coef_q[n] <= '0;
        tmp_q[n]  <= '0;
        res_q[n]  <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          for (int n = 0; n < NUM_COEF; n++) coef_q[n] <= coef_i[n*COEF_W +: COEF_W];
          scale_q  <= scale_i;
          bypass_q <= bypass_i;
          state_q  <= ST_ROW;
        end
        ST_ROW: begin
          for (int n = 0; n < NUM_COEF; n++) tmp_q[n] <= row_d[n];
          state_q <= ST_COL;
        end
        default: begin
          for (int n = 0; n < NUM_COEF; n++) res_q[n] <= res_d[n];
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  generate
    for (genvar n = 0; n < NUM_COEF; n++) begin : g_res
      assign res_o[n*COEF_W +: COEF_W] = res_q[n];
    end
  endgenerate
endmodule

// File: rtl/dcq_checker.sv
module dcq_checker #(
  parameter int RES_W = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] res_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> ##2 done_o); // R8

  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i && !busy_o, 3)); // R8

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_o)); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R9

  AST_IDLE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
endmodule

bind dc_hadamard_dequant dcq_checker #(.RES_W(dcq_pkg::NUM_COEF*COEF_W)) i_dcq_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .res_o  (res_o)
);

// File: tb/test_dc_hadamard_dequant.sv
module test_dc_hadamard_dequant;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         bypass_i = 1'b0;
  logic [21:0]  scale_i = '0;
  logic [255:0] coef_i = '0;
  logic         busy_o, done_o;
  logic [255:0] res_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  dc_hadamard_dequant i_dc_hadamard_dequant (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bypass_i(bypass_i),
    .scale_i(scale_i), .coef_i(coef_i), .busy_o(busy_o), .done_o(done_o), .res_o(res_o)
  );

  function automatic int lane_a(int k);
    case (k) 0: return 0; 1: return 1; 2: return 4; default: return 5; endcase
  endfunction
  function automatic int lane_b(int i);
    case (i) 0: return 0; 1: return 2; 2: return 8; default: return 10; endcase
  endfunction

  function automatic logic [255:0] model(input logic [255:0] c, input int scale, input bit byp);
    longint a [16];
    longint t [16];
    longint o [16];
    logic [255:0] r;
    longint eff, p, v, q;
    int sh;
    for (int n = 0; n < 16; n++) a[n] = longint'($signed(c[n*16 +: 16]));
    r = '0;
    if (byp) begin
      for (int rr = 0; rr < 4; rr++)
        for (int cc = 0; cc < 4; cc++)
          r[(lane_a(cc) + lane_b(rr))*16 +: 16] = c[(rr*4+cc)*16 +: 16];
      return r;
    end
    for (int rr = 0; rr < 4; rr++) begin
      t[rr*4+0] = (a[rr*4]+a[rr*4+1]) + (a[rr*4+2]+a[rr*4+3]);
      t[rr*4+1] = (a[rr*4]+a[rr*4+1]) - (a[rr*4+2]+a[rr*4+3]);
      t[rr*4+2] = (a[rr*4]-a[rr*4+1]) - (a[rr*4+2]-a[rr*4+3]);
      t[rr*4+3] = (a[rr*4]-a[rr*4+1]) + (a[rr*4+2]-a[rr*4+3]);
    end
    for (int i = 0; i < 4; i++) begin
      o[0] = (t[i]+t[8+i]) + (t[4+i]+t[12+i]);
      o[1] = (t[i]-t[8+i]) + (t[4+i]-t[12+i]);
      o[2] = (t[i]-t[8+i]) - (t[4+i]-t[12+i]);
      o[3] = (t[i]+t[8+i]) - (t[4+i]+t[12+i]);
      for (int k = 0; k < 4; k++) begin
        if (scale > 32767) begin eff = longint'(scale) >> 7; sh = 1; end
        else begin eff = longint'(scale); sh = 8; end
        v = o[k];
        p = v * eff + (longint'(1) <<< (sh - 1));
        q = p >>> sh;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        r[(lane_a(k) + lane_b(i))*16 +: 16] = q[15:0];
      end
    end
    return r;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [255:0] exp);
    for (int l = 0; l < 16; l++) begin
      n_chk++;
      if (res_o[l*16 +: 16] !== exp[l*16 +: 16]) begin
        n_err++;
        $display("FAIL %s lane %0d: actual %0d expected %0d", req, l,
                 $signed(res_o[l*16 +: 16]), $signed(exp[l*16 +: 16]));
      end
    end
  endtask

  // drive one transfer and check latency, pulse and result
  task automatic run(input string req, input logic [255:0] c, input int scale, input bit byp);
    @(negedge clk_i);
    coef_i = c; scale_i = 22'(scale); bypass_i = byp; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check_bit({req, " R9 busy"}, busy_o, 1'b1);
    check_bit({req, " R8 early"}, done_o, 1'b0);
    @(negedge clk_i);
    check_bit({req, " R8 early"}, done_o, 1'b0);
    @(negedge clk_i);
    check_bit({req, " R8 done"}, done_o, 1'b1);
    check_vec(req, model(c, scale, byp));
    @(negedge clk_i);
    check_bit({req, " R8 pulse"}, done_o, 1'b0);
  endtask

  function automatic logic [255:0] pack(input int v [16]);
    logic [255:0] r;
    for (int n = 0; n < 16; n++) r[n*16 +: 16] = 16'(v[n]);
    return r;
  endfunction

  task automatic t_reset();
    check_bit("R10 done", done_o, 1'b0);
    check_bit("R10 busy", busy_o, 1'b0);
    check_vec("R10 res", '0);
  endtask

  task automatic t_impulse();
    int v [16];
    for (int n = 0; n < 16; n++) v[n] = 0;
    v[0] = 10;
    run("R1 R2 R3 impulse", pack(v), 256, 1'b0);
    check_vec("R3 impulse all ten", {16{16'd10}});
  endtask

  task automatic t_patterns();
    int v [16];
    for (int n = 0; n < 16; n++) v[n] = n*37 - 300;
    run("R1 R2 R4 ramp", pack(v), 1234, 1'b0);
    for (int n = 0; n < 16; n++) v[n] = 0;
    v[5] = 100; v[14] = -77;
    run("R4 sparse", pack(v), 256, 1'b0);
    for (int n = 0; n < 16; n++) v[n] = (n % 3 == 0) ? -1000 + n : 2000 - n*n;
    run("R2 R4 mixed", pack(v), 3000, 1'b0);
  endtask

  task automatic t_round();
    int v [16];
    for (int n = 0; n < 16; n++) v[n] = 0;
    v[0] = -1;
    run("R3 neg round", pack(v), 128, 1'b0);
    check_vec("R3 zero", '0);
    run("R3 neg floor", pack(v), 129, 1'b0);
    check_vec("R3 minus one", {16{16'hFFFF}});
  endtask

  task automatic t_large();
    int v [16];
    for (int n = 0; n < 16; n++) v[n] = 0;
    v[0] = 50;
    run("R5 big", pack(v), 40000, 1'b0);
    check_vec("R5 value", {16{16'd7800}});
    for (int n = 0; n < 16; n++) v[n] = 3 - n;
    run("R5 big ramp", pack(v), 2000000, 1'b0);
  endtask

  task automatic t_sat();
    int v [16];
    for (int n = 0; n < 16; n++) v[n] = 32767;
    run("R6 high", pack(v), 4096, 1'b0);
    for (int n = 0; n < 16; n++) v[n] = -32768;
    run("R6 low", pack(v), 100000, 1'b0);
  endtask

  task automatic t_bypass();
    int v [16];
    for (int n = 0; n < 16; n++) v[n] = 1000 * n - 7;
    run("R7 bypass", pack(v), 999, 1'b1);
  endtask

  task automatic t_busy();
    int v [16], w [16];
    logic [255:0] exp;
    for (int n = 0; n < 16; n++) begin v[n] = n + 1; w[n] = -500; end
    exp = model(pack(v), 700, 1'b0);
    @(negedge clk_i);
    coef_i = pack(v); scale_i = 22'd700; bypass_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    coef_i = pack(w); scale_i = 22'd5; bypass_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    check_bit("R9 done", done_o, 1'b1);
    check_vec("R9 ignored start", exp);
    @(negedge clk_i);
    check_bit("R9 single pulse", done_o, 1'b0);
    check_bit("R9 idle", busy_o, 1'b0);
    @(negedge clk_i);
    check_bit("R9 no second done", done_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_impulse();
    t_patterns();
    t_round();
    t_large();
    t_sat();
    t_bypass();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 50000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule